// File: doc/BRIEF.md
# Grouped Vectored Interrupt Expander

This block sits between a wide set of peripheral interrupt requests and a processor core. Ninety-six request inputs are split into twelve fixed groups of eight. Each group has its own edge-latched flags and per-source enables, and it merges its enabled, flagged sources into one line. The twelve lines feed a small core-level stage that holds a line flag register, a line enable register and a global mask. When the core acknowledges, the block hands back a vector that belongs to the winning source. In the same cycle it clears that source's flag and the line flag, so software never has to work out which peripheral fired.

Vectors come from a 96-entry table that software writes through the register port. Entry `g*8+s` serves source `s` of group `g`. When the table is switched off, a fixed fallback vector for each line is used instead. Each group also has a service bit. The bit is set on acknowledge and holds off further requests from that group until software clears it, which gives a simple end-of-service handshake per group.

Top module: `irqx_expander`

## Requirements
- R1: Source `s` of group `g` is `src_i[g*8+s]`. A rising edge sampled on `src_i` sets its flag on that clock edge. The flag stays set until the source is acknowledged or until software writes a 1 to its bit in the group flag register (address `0x020+g`, bits 7:0, write-one-to-clear).
- R2: The group source enable register (address `0x010+g`, bits 7:0, reset 0) gates the sources. A flagged source whose enable bit is 0 does not drive its group line and does not set the line flag. Its own flag still shows in the group flag register.
- R3: The line flag register (address `0x002`, bits 11:0, read-only) sets bit `g` one cycle after group `g` drives its line. The line enable register (address `0x001`, bits 11:0) gates `irq_o`: a flagged line with enable 0 raises no request.
- R4: Bit 0 of the control register (address `0x000`) is the global mask. While it is 1, `irq_o` stays low whatever is flagged.
- R5: Among the flagged, enabled lines, the lowest group index wins and is shown on `irq_line_o`. Within a group, the lowest enabled, flagged source index wins.
- R6: When `irq_ack_i` is high while `irq_o` is high, the block clears the winning source's flag and the line flag, and sets the group's service bit (address `0x003`, bits 11:0, write-one-to-clear). A group whose service bit is set drives no request until that bit is cleared.
- R7: While `irq_o` is high, `irq_vec_o` carries the vector for the current winner in the same cycle. With table enable (control bit 1) set, the vector is table entry `g*8+s`. With it clear, the vector is `FALLBACK_BASE + 4*g` (default base `0x00000D00`). While `irq_o` is low, `irq_vec_o` is 0.
- R8: After reset, all flags, source enables, line enables and service bits are 0. The control register reads 1 (mask set, table enable clear), and `irq_o` is low.
- R9: The vector table is written and read back through the register port at addresses `0x100+i` for `i` from 0 to 95.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 96 | Peripheral request inputs, edge-sensitive |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register address; bit 8 selects the vector table |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request to the core |
| irq_ack_i | input | 1 | Core acknowledge |
| irq_line_o | output | 4 | Index of the winning line |
| irq_vec_o | output | 32 | Vector of the winning source |

## Verification
The hardest case to reach is a group that still holds enabled flags after one of its sources has been serviced. It has to stay silent while its service bit is set, yield to a lower-priority group, and then win again once the bit is cleared. Random bursts of sparse edges are applied across all twelve groups with random enable patterns, then drained one acknowledge at a time. Because the drain clears each service bit only after the acknowledge, many groups hold several sources at once, so re-arbitration after each clear happens constantly. Directed steps cover the masked, disabled-line, disabled-source and fallback-vector cases, where a flag is present but must not produce a request.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int ADDR_W = 9;
  // page select in reg_addr[7:4] when reg_addr[8] == 0
  localparam logic [3:0] PG_CORE     = 4'h0;
  localparam logic [3:0] PG_SRC_EN   = 4'h1;
  localparam logic [3:0] PG_SRC_FLAG = 4'h2;
  // core page offsets
  localparam logic [3:0] RG_CTRL      = 4'h0;
  localparam logic [3:0] RG_LINE_EN   = 4'h1;
  localparam logic [3:0] RG_LINE_FLAG = 4'h2;
  localparam logic [3:0] RG_GRP_SVC   = 4'h3;
endpackage

// File: rtl/irqx_group.sv
module irqx_group #(
  parameter int GRP_SIZE = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [GRP_SIZE-1:0]         src_i,
  input  logic                        en_we_i,
  input  logic                        flag_w1c_i,
  input  logic [GRP_SIZE-1:0]         wdata_i,
  input  logic                        blocked_i,
  input  logic                        serviced_i,
  output logic [GRP_SIZE-1:0]         en_o,
  output logic [GRP_SIZE-1:0]         flag_o,
  output logic                        req_o,
  output logic [$clog2(GRP_SIZE)-1:0] sel_o
);
  localparam int SEL_W = $clog2(GRP_SIZE);

  logic [GRP_SIZE-1:0] src_q, flag_q, en_q, live, rise, svc_mask, clr_mask;

  assign live = flag_q & en_q;
  assign rise = src_i & ~src_q;

  always_comb begin
    sel_o = '0;
    for (int i = GRP_SIZE - 1; i >= 0; i--) begin
      if (live[i]) sel_o = SEL_W'(i);
    end
  end

  assign svc_mask = serviced_i ? (GRP_SIZE'(1) << sel_o) : '0;
  assign clr_mask = flag_w1c_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      src_q  <= src_i;
      // a fresh edge wins over a clear in the same cycle
      flag_q <= (flag_q & ~clr_mask & ~svc_mask) | rise;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign req_o  = (|live) & ~blocked_i;
endmodule

// File: rtl/irqx_core.sv
module irqx_core #(
  parameter int NUM_GRP = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_GRP-1:0]         grp_req_i,
  input  logic                       ack_i,
  input  logic                       ctrl_we_i,
  input  logic                       cen_we_i,
  input  logic                       svc_w1c_i,
  input  logic [NUM_GRP-1:0]         wdata_i,
  output logic                       irq_o,
  output logic [$clog2(NUM_GRP)-1:0] line_o,
  output logic                       take_o,
  output logic [NUM_GRP-1:0]         cen_o,
  output logic [NUM_GRP-1:0]         cflag_o,
  output logic [NUM_GRP-1:0]         svc_o,
  output logic                       gmask_o,
  output logic                       tbl_en_o
);
  localparam int LINE_W = $clog2(NUM_GRP);

  logic [NUM_GRP-1:0] cen_q, cflag_q, svc_q, pending, svc_hot, svc_clr;
  logic               gmask_q, tbl_en_q;

  assign pending = cflag_q & cen_q;

  always_comb begin
    line_o = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (pending[g]) line_o = LINE_W'(g);
    end
  end

  assign irq_o   = (|pending) & ~gmask_q;
  assign take_o  = irq_o & ack_i;
  assign svc_hot = take_o ? (NUM_GRP'(1) << line_o) : '0;
  assign svc_clr = svc_w1c_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q    <= '0;
      cflag_q  <= '0;
      svc_q    <= '0;
      gmask_q  <= 1'b1;
      tbl_en_q <= 1'b0;
    end else begin
      cflag_q <= (cflag_q | grp_req_i) & ~svc_hot;
      svc_q   <= (svc_q & ~svc_clr) | svc_hot;
      if (cen_we_i) cen_q <= wdata_i;
      if (ctrl_we_i) begin
        gmask_q  <= wdata_i[0];
        tbl_en_q <= wdata_i[1];
      end
    end
  end

  assign cen_o    = cen_q;
  assign cflag_o  = cflag_q;
  assign svc_o    = svc_q;
  assign gmask_o  = gmask_q;
  assign tbl_en_o = tbl_en_q;
endmodule

// File: rtl/irqx_vec_table.sv
module irqx_vec_table #(
  parameter int              NUM_GRP       = 12,
  parameter int              GRP_SIZE      = 8,
  parameter int              VEC_W         = 32,
  parameter logic [VEC_W-1:0] FALLBACK_BASE = 32'h0000_0D00
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [7:0]                  addr_i,
  input  logic [VEC_W-1:0]            wdata_i,
  output logic [VEC_W-1:0]            rdata_o,
  input  logic [$clog2(NUM_GRP)-1:0]  line_i,
  input  logic [$clog2(GRP_SIZE)-1:0] sel_i,
  input  logic                        tbl_en_i,
  output logic [VEC_W-1:0]            vec_o
);
  localparam int SRC_N = NUM_GRP * GRP_SIZE;
  localparam int IDX_W = $clog2(SRC_N);

  logic [VEC_W-1:0] mem [SRC_N];
  logic [IDX_W-1:0] vidx;
  logic             addr_ok;

  assign addr_ok = int'(addr_i) < SRC_N;

  always_ff @(posedge clk_i) begin
    if (we_i && addr_ok) mem[addr_i[IDX_W-1:0]] <= wdata_i;
  end

  assign rdata_o = addr_ok ? mem[addr_i[IDX_W-1:0]] : '0;
  assign vidx    = IDX_W'(int'(line_i) * GRP_SIZE + int'(sel_i));
  assign vec_o   = tbl_en_i ? mem[vidx] : FALLBACK_BASE + (VEC_W'(line_i) << 2);
endmodule

// File: rtl/irqx_expander.sv
module irqx_expander #(
  parameter int               NUM_GRP       = 12,
  parameter int               GRP_SIZE      = 8,
  parameter int               VEC_W         = 32,
  parameter logic [VEC_W-1:0] FALLBACK_BASE = 32'h0000_0D00
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_GRP*GRP_SIZE-1:0]           src_i,
  input  logic                                  reg_we_i,
  input  logic [irqx_pkg::ADDR_W-1:0]           reg_addr_i,
  input  logic [VEC_W-1:0]                      reg_wdata_i,
  output logic [VEC_W-1:0]                      reg_rdata_o,
  output logic                                  irq_o,
  input  logic                                  irq_ack_i,
  output logic [$clog2(NUM_GRP)-1:0]            irq_line_o,
  output logic [VEC_W-1:0]                      irq_vec_o
);
  import irqx_pkg::*;

  localparam int LINE_W = $clog2(NUM_GRP);
  localparam int SEL_W  = $clog2(GRP_SIZE);

  logic             is_tbl, core_pg;
  logic [3:0]       pg, off;
  logic             ctrl_we, cen_we, svc_we;
  logic [NUM_GRP-1:0] grp_req, cen, cflag, gack;
  logic             take, gmask, tbl_en, core_irq;
  logic [LINE_W-1:0] line;
  logic [SEL_W-1:0]  win_sel;
  logic [VEC_W-1:0]  tbl_rdata, vec_raw;
  logic [GRP_SIZE-1:0] gen  [NUM_GRP];
  logic [GRP_SIZE-1:0] gflg [NUM_GRP];
  logic [SEL_W-1:0]    gsel [NUM_GRP];

  assign is_tbl  = reg_addr_i[8];
  assign pg      = reg_addr_i[7:4];
  assign off     = reg_addr_i[3:0];
  assign core_pg = reg_we_i && !is_tbl && pg == PG_CORE;
  assign ctrl_we = core_pg && off == RG_CTRL;
  assign cen_we  = core_pg && off == RG_LINE_EN;
  assign svc_we  = core_pg && off == RG_GRP_SVC;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic en_we, flg_we;
    assign en_we  = reg_we_i && !is_tbl && pg == PG_SRC_EN   && off == 4'(g);
    assign flg_we = reg_we_i && !is_tbl && pg == PG_SRC_FLAG && off == 4'(g);
    irqx_group #(.GRP_SIZE(GRP_SIZE)) u_grp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[g*GRP_SIZE +: GRP_SIZE]),
      .en_we_i    (en_we),
      .flag_w1c_i (flg_we),
      .wdata_i    (reg_wdata_i[GRP_SIZE-1:0]),
      .blocked_i  (gack[g]),
      .serviced_i (take && line == LINE_W'(g)),
      .en_o       (gen[g]),
      .flag_o     (gflg[g]),
      .req_o      (grp_req[g]),
      .sel_o      (gsel[g])
    );
  end

  irqx_core #(.NUM_GRP(NUM_GRP)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .grp_req_i (grp_req),
    .ack_i     (irq_ack_i),
    .ctrl_we_i (ctrl_we),
    .cen_we_i  (cen_we),
    .svc_w1c_i (svc_we),
    .wdata_i   (reg_wdata_i[NUM_GRP-1:0]),
    .irq_o     (core_irq),
    .line_o    (line),
    .take_o    (take),
    .cen_o     (cen),
    .cflag_o   (cflag),
    .svc_o     (gack),
    .gmask_o   (gmask),
    .tbl_en_o  (tbl_en)
  );

  always_comb begin
    win_sel = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (line == LINE_W'(g)) win_sel = gsel[g];
    end
  end

  irqx_vec_table #(
    .NUM_GRP(NUM_GRP), .GRP_SIZE(GRP_SIZE), .VEC_W(VEC_W), .FALLBACK_BASE(FALLBACK_BASE)
  ) u_tbl (
    .clk_i    (clk_i),
    .we_i     (reg_we_i && is_tbl),
    .addr_i   (reg_addr_i[7:0]),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (tbl_rdata),
    .line_i   (line),
    .sel_i    (win_sel),
    .tbl_en_i (tbl_en),
    .vec_o    (vec_raw)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (is_tbl) begin
      reg_rdata_o = tbl_rdata;
    end else if (pg == PG_CORE) begin
      case (off)
        RG_CTRL:      reg_rdata_o = VEC_W'({tbl_en, gmask});
        RG_LINE_EN:   reg_rdata_o = VEC_W'(cen);
        RG_LINE_FLAG: reg_rdata_o = VEC_W'(cflag);
        RG_GRP_SVC:   reg_rdata_o = VEC_W'(gack);
        default:      reg_rdata_o = '0;
      endcase
    end else begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (off == 4'(g)) begin
          if (pg == PG_SRC_EN)   reg_rdata_o = VEC_W'(gen[g]);
          if (pg == PG_SRC_FLAG) reg_rdata_o = VEC_W'(gflg[g]);
        end
      end
    end
  end

  assign irq_o      = core_irq;
  assign irq_line_o = line;
  assign irq_vec_o  = core_irq ? vec_raw : '0;
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
  parameter int NUM_GRP = 12,
  parameter int LINE_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_o,
  input logic               irq_ack_i,
  input logic [LINE_W-1:0]  irq_line_o,
  input logic               gmask,
  input logic [NUM_GRP-1:0] gack
);
  logic [LINE_W-1:0] line_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= irq_line_o;
  end

  assert_mask_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask |-> !irq_o);

  assert_line_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int'(irq_line_o) < NUM_GRP);

  assert_ack_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_ack_i) |=> gack[line_q]);

  assert_ack_drops_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_ack_i) |=> !(irq_o && irq_line_o == line_q));

  assert_no_blocked_winner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !gack[irq_line_o]);
endmodule

bind irqx_expander irqx_checker #(.NUM_GRP(NUM_GRP), .LINE_W(LINE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .irq_ack_i  (irq_ack_i),
  .irq_line_o (irq_line_o),
  .gmask      (gmask),
  .gack       (gack)
);

// File: tb/tb_irqx_expander.sv
`timescale 1ns/100ps
module tb_irqx_expander;
  localparam int NG = 12;
  localparam int GS = 8;
  localparam int NS = NG * GS;
  localparam logic [31:0] FB = 32'h0000_0D00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic        we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        ack = 1'b0;
  logic [3:0]  line;
  logic [31:0] vec;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0]  mflag [NG];
  logic [7:0]  men   [NG];
  logic [31:0] mram  [NS];
  bit          mtbl = 1'b0;

  always #2.5 clk = ~clk;

  irqx_expander dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .irq_ack_i(ack),
    .irq_line_o(line), .irq_vec_o(vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic set_en(input int g, input logic [7:0] v);
    wr(9'h010 + 9'(g), 32'(v));
    men[g] = v;
  endtask

  task automatic clr_flags(input int g, input logic [7:0] v);
    wr(9'h020 + 9'(g), 32'(v));
    mflag[g] &= ~v;
  endtask

  task automatic pulse(input logic [NS-1:0] p);
    @(negedge clk);
    src = p;
    for (int i = 0; i < NS; i++) if (p[i]) mflag[i/GS][i%GS] = 1'b1;
    @(negedge clk);
    src = '0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_line();
    for (int g = 0; g < NG; g++) if ((mflag[g] & men[g]) != 0) return g;
    return -1;
  endfunction

  function automatic int exp_sel(input int g);
    for (int s = 0; s < GS; s++) if (mflag[g][s] && men[g][s]) return s;
    return 0;
  endfunction

  function automatic logic [31:0] exp_vec(input int g, input int s);
    return mtbl ? mram[g*GS+s] : FB + 32'(4*g);
  endfunction

  task automatic do_ack(input int g, input int s);
    @(negedge clk);
    ack = 1'b1;
    @(posedge clk); #1;
    ack = 1'b0;
    mflag[g][s] = 1'b0;
  endtask

  // service everything pending, one acknowledge per step
  task automatic drain(input string tag);
    int guard = 0;
    while (exp_line() >= 0 && guard < 200) begin
      int g, s;
      g = exp_line();
      s = exp_sel(g);
      @(negedge clk);
      check({tag, " R5 irq"}, 32'(irq), 32'd1);
      check({tag, " R5 line"}, 32'(line), 32'(g));
      check({tag, " R7 vec"}, vec, exp_vec(g, s));
      do_ack(g, s);
      wr(9'h003, 32'(1) << g);
      wait_n(2);
      guard++;
    end
    @(negedge clk);
    check({tag, " R6 idle after drain"}, 32'(irq), 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    for (int g = 0; g < NG; g++) begin mflag[g] = '0; men[g] = '0; end
    for (int i = 0; i < NS; i++) mram[i] = $urandom;
    wait_n(3);
    rst_n = 1'b1;

    // reset state
    rd(9'h000, r); check("R8 ctrl reset", r, 32'h1);
    rd(9'h001, r); check("R8 line enable reset", r, 32'h0);
    rd(9'h003, r); check("R8 service reset", r, 32'h0);
    rd(9'h025, r); check("R8 group flag reset", r, 32'h0);
    check("R8 irq reset", 32'(irq), 32'd0);

    // disabled source: flag latched, line untouched
    wr(9'h001, 32'hFFF);
    set_en(2, 8'h0F);
    pulse(NS'(1) << (2*GS + 5));
    wait_n(2);
    rd(9'h022, r); check("R1 flag latched", r, 32'h20);
    rd(9'h002, r); check("R2 disabled source no line flag", r, 32'h0);

    // enabled source while masked
    pulse(NS'(1) << (2*GS + 1));
    wait_n(3);
    rd(9'h002, r); check("R3 line flag set", r, 32'h4);
    check("R4 masked", 32'(irq), 32'd0);

    // unmask, table off: fallback vector
    wr(9'h000, 32'h0);
    @(negedge clk);
    check("R4 unmasked irq", 32'(irq), 32'd1);
    check("R5 line", 32'(line), 32'd2);
    check("R7 fallback vec", vec, FB + 32'd8);

    // line enable gating
    wr(9'h001, 32'hFFB);
    @(negedge clk);
    check("R3 line disabled", 32'(irq), 32'd0);
    wr(9'h001, 32'hFFF);

    // write-one-to-clear of the disabled source
    clr_flags(2, 8'h20);
    rd(9'h022, r); check("R1 w1c flag", r, 32'h02);

    // vector table access
    for (int i = 0; i < NS; i++) wr(9'h100 + 9'(i), mram[i]);
    rd(9'h100 + 9'd17, r); check("R9 table readback 17", r, mram[17]);
    rd(9'h100 + 9'd95, r); check("R9 table readback 95", r, mram[95]);

    // priority across and within groups, table on
    set_en(0, 8'hFF);
    pulse((NS'(1) << 6) | (NS'(1) << 3) | (NS'(1) << (2*GS)));
    wr(9'h000, 32'h2);
    mtbl = 1'b1;
    wait_n(3);
    check("R5 lowest group", 32'(line), 32'd0);
    check("R7 table vec low source", vec, mram[3]);

    // acknowledge: group 0 blocked, group 2 takes over
    do_ack(0, 3);
    rd(9'h003, r); check("R6 service bit set", r, 32'h1);
    rd(9'h020, r); check("R6 serviced flag cleared", r, 32'h40);
    check("R6 blocked group yields", 32'(line), 32'd2);
    check("R6 next vec", vec, mram[2*GS]);
    wr(9'h003, 32'h1);
    wait_n(2);
    check("R6 group returns", 32'(line), 32'd0);
    check("R6 returned vec", vec, mram[6]);
    drain("directed");

    // random bursts
    for (int it = 0; it < 40; it++) begin
      logic [NS-1:0] p;
      for (int g = 0; g < NG; g++) set_en(g, 8'($urandom));
      for (int w = 0; w < NS/32; w++) p[w*32 +: 32] = $urandom & $urandom & $urandom;
      pulse(p);
      wait_n(3);
      drain("random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule